// File: doc/BRIEF.md
# SPI Command Engine with Shared Byte Buffer

This block is a half-duplex SPI master that software runs through a 200-byte register window with byte-wide writes and reads. Software sets up four things: a one-byte command code, a count of bytes to send, a count of bytes to fetch, and a target select line. It places the outgoing payload in an on-chip byte buffer and then sets a start bit.

The engine then pulls one select line low and shifts out the command code. The outgoing payload follows, taken from the buffer. The engine then clocks in the requested number of reply bytes, which it stores in the same buffer right after the payload. A busy flag stays set for the whole command, and software polls it.

The buffer has one internal pointer. The pointer advances once for each payload byte sent and once for each reply byte stored. Software can zero it with a self-clearing bit. The serial clock is the system clock divided by a fixed ratio. The bus runs in mode 0 (clock idles low, data sampled on the rising edge) with the most significant bit first.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every register reads 0x00 and all select lines are high. The command code is at 0x00, the send count at 0x48 and the fetch count at 0x4B. At 0x02, bit 0 starts a command and bit 4 zeroes the buffer pointer; both read back as 0. At 0x03, bit 7 is the read-only busy flag.
- R2: The select register at 0x1D keeps only bits 1:0; its upper bits read 0. During a command, only cs_n bit N is low, where N is the latched select value.
- R3: A command shifts the command code first, then the send-count bytes taken from the buffer at the pointer onward, then the fetch-count bytes. Each byte goes MSB first. Each bit takes 4 clocks, with sclk low for 2 and high for 2. mosi changes only while sclk is low. The bit periods of all bytes follow each other with no gap.
- R4: Select goes low 4 clocks before the first bit period starts. It stays low for 4 clocks after the last bit period ends, then goes high.
- R5: Busy reads 1 from the cycle after the start write until the cycle in which select goes high. Busy clears in that same cycle.
- R6: Reply bytes are sampled from miso on rising sclk edges only while fetching. Fetched byte i is stored at buffer address 0x80 + pointer + send count + i. miso is ignored while the code and payload are sent.
- R7: The buffer spans 0x80 to 0xC7 (72 bytes). The pointer advances by send count plus fetch count per command and is not zeroed automatically. A later command continues from where the last one ended unless the clear bit is written.
- R8: While busy, these writes are ignored: the start bit, the clear bit and buffer writes. Writes to the code, count and select registers update their read-back value but do not change the running command.
- R9: mosi is low when idle, during the select lead and trail time, and while reply bytes are fetched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 8 | Write byte address |
| wr_data_i | input | 8 | Write byte data |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 8 | Read byte data (combinational) |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to target |
| miso_i | input | 1 | Serial data from target |
| cs_n_o | output | 4 | Active-low select lines |

## Verification
The assertions check the following on every cycle:
- at most one select line is low;
- all select lines are high and sclk and mosi are low whenever the engine is idle;
- mosi holds steady while sclk is high;
- busy only rises after a start write;
- the select pattern stays fixed for the whole command.

Only the bench scenarios can show the rest:
- the exact lead, bit and trail cycle counts;
- the byte order on mosi;
- where fetched bytes land in the buffer and how the pointer carries across commands;
- that writes made while busy leave the running command and the buffer untouched.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int CNT_W = 8;

    localparam logic [7:0] A_OPCODE = 8'h00;
    localparam logic [7:0] A_TRIG   = 8'h02;
    localparam logic [7:0] A_STAT   = 8'h03;
    localparam logic [7:0] A_CSSEL  = 8'h1D;
    localparam logic [7:0] A_TXCNT  = 8'h48;
    localparam logic [7:0] A_RXCNT  = 8'h4B;

    localparam int TRIG_EXEC_BIT  = 0;
    localparam int TRIG_CLEAR_BIT = 4;
    localparam int STAT_BUSY_BIT  = 7;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LEAD,
        SEQ_SHIFT,
        SEQ_TRAIL
    } seq_state_e;
endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
    parameter int DEPTH = 72,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [7:0]       wr_byte_i,
    input  logic [PTR_W-1:0] rda_idx_i,
    output logic [7:0]       rda_byte_o,
    input  logic [PTR_W-1:0] rdb_idx_i,
    output logic [7:0]       rdb_byte_o
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i && (int'(wr_idx_i) < DEPTH)) begin
            mem_q[wr_idx_i] <= wr_byte_i;
        end
    end

    always_comb begin
        rda_byte_o = (int'(rda_idx_i) < DEPTH) ? mem_q[rda_idx_i] : 8'h00;
        rdb_byte_o = (int'(rdb_idx_i) < DEPTH) ? mem_q[rdb_idx_i] : 8'h00;
    end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] load_byte_i,
    input  logic       miso_i,
    output logic       last_o,
    output logic [7:0] rx_byte_o,
    output logic       sclk_o,
    output logic       mosi_o
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;

    typedef struct packed {
        logic            active;
        logic [PH_W-1:0] phase;
        logic [2:0]      bitcnt;
        logic [7:0]      tx_sr;
        logic [7:0]      rx_sr;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d  = shf_q;
        last_o = shf_q.active && (shf_q.phase == PH_W'(DIV-1)) && (shf_q.bitcnt == 3'd0);
        if (!shf_q.active) begin
            if (load_i) begin
                shf_d.active = 1'b1;
                shf_d.phase  = '0;
                shf_d.bitcnt = 3'd7;
                shf_d.tx_sr  = load_byte_i;
            end
        end else begin
            shf_d.phase = (shf_q.phase == PH_W'(DIV-1)) ? '0 : shf_q.phase + 1'b1;
            if (shf_q.phase == PH_W'(HALF-1)) begin
                shf_d.rx_sr = {shf_q.rx_sr[6:0], miso_i};
            end
            if (shf_q.phase == PH_W'(DIV-1)) begin
                if (shf_q.bitcnt == 3'd0) begin
                    if (load_i) begin
                        shf_d.bitcnt = 3'd7;
                        shf_d.tx_sr  = load_byte_i;
                    end else begin
                        shf_d.active = 1'b0;
                        shf_d.tx_sr  = 8'h00;
                    end
                end else begin
                    shf_d.bitcnt = shf_q.bitcnt - 3'd1;
                    shf_d.tx_sr  = {shf_q.tx_sr[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign rx_byte_o = shf_q.rx_sr;
    assign sclk_o    = shf_q.active && (int'(shf_q.phase) >= HALF);
    assign mosi_o    = shf_q.active && shf_q.tx_sr[7];
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH  = 72,
    parameter int PTR_W  = $clog2(DEPTH),
    parameter int DIV    = 4,
    parameter int NUM_CS = 4,
    parameter int CS_W   = $clog2(NUM_CS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_i,
    input  logic             clear_i,
    input  logic [7:0]       opcode_i,
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic [CS_W-1:0]  cs_sel_i,
    input  logic [7:0]       fifo_byte_i,
    input  logic             last_i,
    input  logic [7:0]       rx_byte_i,
    output logic             busy_o,
    output logic [NUM_CS-1:0] cs_n_o,
    output logic             load_o,
    output logic [7:0]       load_byte_o,
    output logic [PTR_W-1:0] fifo_rd_idx_o,
    output logic             fifo_wr_en_o,
    output logic [PTR_W-1:0] fifo_wr_idx_o,
    output logic [7:0]       fifo_wr_byte_o
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        seq_state_e       st;
        logic [PH_W-1:0]  cnt;
        logic [7:0]       opcode;
        logic [CNT_W-1:0] rem_tx;
        logic [CNT_W-1:0] rem_rx;
        logic [CS_W-1:0]  cs_sel;
        logic             cur_rx;
        logic [PTR_W-1:0] ptr;
    } seq_t;

    seq_t seq_d, seq_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH-1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        seq_d          = seq_q;
        load_o         = 1'b0;
        load_byte_o    = 8'h00;
        fifo_wr_en_o   = 1'b0;
        fifo_rd_idx_o  = seq_q.ptr;
        fifo_wr_idx_o  = seq_q.ptr;
        fifo_wr_byte_o = rx_byte_i;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (clear_i) seq_d.ptr = '0;
                if (exec_i) begin
                    seq_d.st     = SEQ_LEAD;
                    seq_d.cnt    = '0;
                    seq_d.opcode = opcode_i;
                    seq_d.rem_tx = tx_cnt_i;
                    seq_d.rem_rx = rx_cnt_i;
                    seq_d.cs_sel = cs_sel_i;
                end
            end
            SEQ_LEAD: begin
                seq_d.cnt = seq_q.cnt + 1'b1;
                if (seq_q.cnt == PH_W'(DIV-1)) begin
                    load_o       = 1'b1;
                    load_byte_o  = seq_q.opcode;
                    seq_d.cur_rx = 1'b0;
                    seq_d.st     = SEQ_SHIFT;
                end
            end
            SEQ_SHIFT: begin
                if (last_i) begin
                    if (seq_q.cur_rx) begin
                        fifo_wr_en_o = 1'b1;
                        seq_d.ptr    = ptr_inc(seq_q.ptr);
                    end
                    if (seq_q.rem_tx != '0) begin
                        load_o       = 1'b1;
                        load_byte_o  = fifo_byte_i;
                        seq_d.ptr    = ptr_inc(seq_q.ptr);
                        seq_d.rem_tx = seq_q.rem_tx - 1'b1;
                        seq_d.cur_rx = 1'b0;
                    end else if (seq_q.rem_rx != '0) begin
                        load_o       = 1'b1;
                        load_byte_o  = 8'h00;
                        seq_d.rem_rx = seq_q.rem_rx - 1'b1;
                        seq_d.cur_rx = 1'b1;
                    end else begin
                        seq_d.st  = SEQ_TRAIL;
                        seq_d.cnt = '0;
                    end
                end
            end
            SEQ_TRAIL: begin
                seq_d.cnt = seq_q.cnt + 1'b1;
                if (seq_q.cnt == PH_W'(DIV-1)) begin
                    seq_d.st = SEQ_IDLE;
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign busy_o = (seq_q.st != SEQ_IDLE);
    assign cs_n_o = busy_o ? ~(NUM_CS'(1) << seq_q.cs_sel) : '1;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int FIFO_BASE  = 128,
    parameter int FIFO_DEPTH = 72,
    parameter int NUM_CS     = 4,
    parameter int SCLK_DIV   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [7:0]        rd_addr_i,
    output logic [7:0]        rd_data_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [NUM_CS-1:0] cs_n_o
);
    localparam int PTR_W = $clog2(FIFO_DEPTH);
    localparam int CS_W  = $clog2(NUM_CS);

    typedef struct packed {
        logic [7:0]       opcode;
        logic [CNT_W-1:0] tx_cnt;
        logic [CNT_W-1:0] rx_cnt;
        logic [CS_W-1:0]  cs_sel;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             cmd_busy;
    logic             exec_hit, clear_hit, exec_go, clear_go;
    logic             wr_in_fifo, rd_in_fifo;
    logic [PTR_W-1:0] sw_wr_idx, sw_rd_idx;
    logic             fifo_we;
    logic [PTR_W-1:0] fifo_widx;
    logic [7:0]       fifo_wbyte, sw_rd_byte;
    logic [PTR_W-1:0] eng_rd_idx, eng_wr_idx;
    logic             eng_we;
    logic [7:0]       eng_rd_byte, eng_wr_byte;
    logic             shf_load, shf_last;
    logic [7:0]       shf_load_byte, shf_rx_byte;

    assign wr_in_fifo = (int'(wr_addr_i) >= FIFO_BASE) && (int'(wr_addr_i) < FIFO_BASE + FIFO_DEPTH);
    assign rd_in_fifo = (int'(rd_addr_i) >= FIFO_BASE) && (int'(rd_addr_i) < FIFO_BASE + FIFO_DEPTH);
    assign sw_wr_idx  = PTR_W'(wr_addr_i - 8'(FIFO_BASE));
    assign sw_rd_idx  = PTR_W'(rd_addr_i - 8'(FIFO_BASE));

    assign exec_hit  = wr_en_i && (wr_addr_i == A_TRIG) && wr_data_i[TRIG_EXEC_BIT];
    assign clear_hit = wr_en_i && (wr_addr_i == A_TRIG) && wr_data_i[TRIG_CLEAR_BIT];
    assign exec_go   = exec_hit && !cmd_busy;
    assign clear_go  = clear_hit && !cmd_busy;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                A_OPCODE: regs_d.opcode = wr_data_i;
                A_TXCNT:  regs_d.tx_cnt = wr_data_i;
                A_RXCNT:  regs_d.rx_cnt = wr_data_i;
                A_CSSEL:  regs_d.cs_sel = wr_data_i[CS_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        if (cmd_busy) begin
            fifo_we    = eng_we;
            fifo_widx  = eng_wr_idx;
            fifo_wbyte = eng_wr_byte;
        end else begin
            fifo_we    = wr_en_i && wr_in_fifo;
            fifo_widx  = sw_wr_idx;
            fifo_wbyte = wr_data_i;
        end
    end

    always_comb begin
        rd_data_o = 8'h00;
        if (rd_in_fifo) begin
            rd_data_o = sw_rd_byte;
        end else begin
            unique case (rd_addr_i)
                A_OPCODE: rd_data_o = regs_q.opcode;
                A_STAT:   rd_data_o = {cmd_busy, 7'd0};
                A_CSSEL:  rd_data_o = 8'(regs_q.cs_sel);
                A_TXCNT:  rd_data_o = regs_q.tx_cnt;
                A_RXCNT:  rd_data_o = regs_q.rx_cnt;
                default:  rd_data_o = 8'h00;
            endcase
        end
    end

    spi_cmd_fifo #(.DEPTH(FIFO_DEPTH), .PTR_W(PTR_W)) u_fifo (
        .clk        (clk),
        .wr_en_i    (fifo_we),
        .wr_idx_i   (fifo_widx),
        .wr_byte_i  (fifo_wbyte),
        .rda_idx_i  (sw_rd_idx),
        .rda_byte_o (sw_rd_byte),
        .rdb_idx_i  (eng_rd_idx),
        .rdb_byte_o (eng_rd_byte)
    );

    spi_cmd_seq #(
        .DEPTH(FIFO_DEPTH), .PTR_W(PTR_W), .DIV(SCLK_DIV), .NUM_CS(NUM_CS), .CS_W(CS_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .exec_i         (exec_go),
        .clear_i        (clear_go),
        .opcode_i       (regs_d.opcode),
        .tx_cnt_i       (regs_d.tx_cnt),
        .rx_cnt_i       (regs_d.rx_cnt),
        .cs_sel_i       (regs_d.cs_sel),
        .fifo_byte_i    (eng_rd_byte),
        .last_i         (shf_last),
        .rx_byte_i      (shf_rx_byte),
        .busy_o         (cmd_busy),
        .cs_n_o         (cs_n_o),
        .load_o         (shf_load),
        .load_byte_o    (shf_load_byte),
        .fifo_rd_idx_o  (eng_rd_idx),
        .fifo_wr_en_o   (eng_we),
        .fifo_wr_idx_o  (eng_wr_idx),
        .fifo_wr_byte_o (eng_wr_byte)
    );

    spi_cmd_shifter #(.DIV(SCLK_DIV)) u_shf (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (shf_load),
        .load_byte_i (shf_load_byte),
        .miso_i      (miso_i),
        .last_o      (shf_last),
        .rx_byte_o   (shf_rx_byte),
        .sclk_o      (sclk_o),
        .mosi_o      (mosi_o)
    );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_req,
    input logic              busy,
    input logic [NUM_CS-1:0] cs_n,
    input logic              sclk,
    input logic              mosi
);
    // R2: never more than one target selected
    a_r2_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    // R5: idle engine releases every select line
    a_r5_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n == {NUM_CS{1'b1}}));

    // R5: busy only starts after a start request
    a_r5_busy_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(exec_req));

    // R8: select pattern frozen during a running command
    a_r8_cs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cs_n));

    // R3: clock idles low outside commands
    a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R3: data steady while clock is high
    a_r3_mosi_steady: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    // R9: data line low when idle
    a_r9_mosi_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_req (exec_hit),
    .busy     (cmd_busy),
    .cs_n     (cs_n_o),
    .sclk     (sclk_o),
    .mosi     (mosi_o)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
    localparam int DEPTH = 72;
    localparam int BASE  = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [7:0] rd_data;
    logic       sclk, mosi, miso;
    logic [3:0] cs_n;

    always #2 clk = ~clk;

    spi_cmd_engine u_spi_cmd_engine (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct packed { logic busy; logic [3:0] cs_n; logic sclk; logic mosi; } exp_t;
    exp_t expq[$];
    logic busy_m = 1'b0;
    bit   mon_on = 0;

    logic [7:0] mem_m [DEPTH];
    int   ptr_m = 0;
    logic [7:0] opc_m = 0, tx_m = 0, rx_m = 0;
    logic [1:0] cs_m = 0;
    logic [7:0] resp_seed = 8'h00;

    bit stream [1024];
    int stream_len = 0;
    int sl_bit = 0;

    assign miso = (sl_bit < stream_len) ? stream[sl_bit] : 1'b1;
    always @(posedge sclk) sl_bit = sl_bit + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    // per-cycle pin comparison (R3, R4, R9 timing and data; R2 select)
    always @(negedge clk) begin
        if (mon_on && !finished) begin
            exp_t e;
            e = (expq.size() > 0) ? expq.pop_front() : exp_t'{1'b0, 4'hF, 1'b0, 1'b0};
            busy_m = e.busy;
            chk({cs_n, sclk, mosi} == {e.cs_n, e.sclk, e.mosi}, "R2 R3 R4 R9 pins",
                int'({cs_n, sclk, mosi}), int'({e.cs_n, e.sclk, e.mosi}));
        end
    end

    function automatic logic [7:0] resp_byte(input int i);
        return 8'(resp_seed + 8'(i * 29));
    endfunction

    task automatic model_exec();
        int ntot;
        logic [3:0] csv;
        logic [7:0] b;
        ntot = 1 + int'(tx_m) + int'(rx_m);
        csv  = ~(4'b0001 << cs_m);
        for (int k = 0; k < 4; k++) expq.push_back({1'b1, csv, 1'b0, 1'b0});
        for (int k = 0; k < ntot; k++) begin
            if (k == 0) b = opc_m;
            else if (k <= int'(tx_m)) b = mem_m[(ptr_m + k - 1) % DEPTH];
            else b = 8'h00;
            for (int bi = 7; bi >= 0; bi--)
                for (int ph = 0; ph < 4; ph++)
                    expq.push_back({1'b1, csv, (ph >= 2), b[bi]});
        end
        for (int k = 0; k < 4; k++) expq.push_back({1'b1, csv, 1'b0, 1'b0});
        stream_len = 0;
        for (int k = 0; k < (1 + int'(tx_m)) * 8; k++) begin
            stream[stream_len] = 1'b1;
            stream_len++;
        end
        for (int i = 0; i < int'(rx_m); i++) begin
            b = resp_byte(i);
            for (int bi = 7; bi >= 0; bi--) begin
                stream[stream_len] = b[bi];
                stream_len++;
            end
            mem_m[(ptr_m + int'(tx_m) + i) % DEPTH] = b;
        end
        sl_bit = 0;
        ptr_m  = (ptr_m + int'(tx_m) + int'(rx_m)) % DEPTH;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        if (a == 8'h00) opc_m = d;
        if (a == 8'h48) tx_m = d;
        if (a == 8'h4B) rx_m = d;
        if (a == 8'h1D) cs_m = d[1:0];
        if (!busy_m) begin
            if (int'(a) >= BASE && int'(a) < BASE + DEPTH) mem_m[int'(a) - BASE] = d;
            if (a == 8'h02 && d[4]) ptr_m = 0;
            if (a == 8'h02 && d[0]) model_exec();
        end
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] expv, input string req);
        logic [7:0] d;
        rd(a, d);
        chk(d == expv, req, int'(d), int'(expv));
    endtask

    task automatic wait_idle();
        logic [7:0] d;
        int guard = 0;
        do begin
            rd(8'h03, d);
            guard++;
        end while (d[7] && guard < 5000);
        chk(!d[7], "R5 busy clears", int'(d), 0);
    endtask

    task automatic fifo_chk(input int start, input int n, input string req);
        for (int i = start; i < start + n; i++) rd_chk(8'(BASE + i), mem_m[i % DEPTH], req);
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = 8'h00;
        repeat (3) @(posedge clk);
        // R1: reset state on pins
        chk(cs_n == 4'hF && !sclk && !mosi, "R1 reset pins", int'({cs_n, sclk, mosi}), 8'h3C);
        #1 rst_n = 1'b1;
        mon_on = 1;
        // R1: reset register values
        rd_chk(8'h00, 8'h00, "R1 opcode reset");
        rd_chk(8'h48, 8'h00, "R1 txcnt reset");
        rd_chk(8'h4B, 8'h00, "R1 rxcnt reset");
        rd_chk(8'h1D, 8'h00, "R2 select reset");
        rd_chk(8'h03, 8'h00, "R1 status reset");
        // R2: only two select bits kept
        wr(8'h1D, 8'hFE);
        rd_chk(8'h1D, 8'h02, "R2 select width");
        // preload buffer
        for (int i = 0; i < 8; i++) wr(8'(BASE + i), 8'(8'hA0 + i));
        fifo_chk(0, 8, "R7 buffer write");
        // command 1: fetch only, R6
        wr(8'h00, 8'h9F); wr(8'h48, 8'd0); wr(8'h4B, 8'd3); wr(8'h1D, 8'd1);
        resp_seed = 8'h3C;
        wr(8'h02, 8'h10);
        wr(8'h02, 8'h01);
        rd_chk(8'h03, 8'h80, "R5 busy set");
        rd_chk(8'h02, 8'h00, "R1 trigger reads zero");
        wait_idle();
        fifo_chk(0, 5, "R6 fetch into buffer");
        // command 2: send then fetch, R3 R6
        wr(8'h80, 8'h11); wr(8'h81, 8'hC3); wr(8'h82, 8'h5A);
        wr(8'h00, 8'h0B); wr(8'h48, 8'd3); wr(8'h4B, 8'd2); wr(8'h1D, 8'd2);
        resp_seed = 8'hE1;
        wr(8'h02, 8'h11);
        wait_idle();
        fifo_chk(0, 6, "R6 fetch after payload");
        // command 3: no clear, pointer continues from 5, R7
        wr(8'h85, 8'h96);
        wr(8'h48, 8'd1); wr(8'h4B, 8'd1); wr(8'h1D, 8'd0);
        resp_seed = 8'h47;
        wr(8'h02, 8'h01);
        wait_idle();
        fifo_chk(4, 4, "R7 pointer carry");
        // command 4: writes during busy ignored, R8
        wr(8'h00, 8'h02); wr(8'h48, 8'd2); wr(8'h4B, 8'd0); wr(8'h1D, 8'd3);
        wr(8'h02, 8'h11);
        wr(8'h02, 8'h01);
        wr(8'h1D, 8'd0);
        wr(8'h80, 8'h55);
        wr(8'h00, 8'h77);
        wr(8'h02, 8'h10);
        wait_idle();
        rd_chk(8'h80, mem_m[0], "R8 buffer write ignored");
        rd_chk(8'h00, 8'h77, "R8 opcode readback");
        rd_chk(8'h1D, 8'h00, "R8 select readback");
        // command 5: pointer was 2 (clear during busy ignored), R7 R8
        wr(8'h48, 8'd0); wr(8'h4B, 8'd1);
        resp_seed = 8'hB8;
        wr(8'h02, 8'h01);
        wait_idle();
        rd_chk(8'h82, 8'hB8, "R8 clear ignored while busy");
        repeat (10) @(posedge clk);
        chk(expq.size() == 0, "R4 model drained", expq.size(), 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule